// File: doc/BRIEF.md
# ADC Under-Threshold Alarm

This block monitors a stream of 12-bit conversion results and raises a sticky alarm flag once a programmed number of results have come in strictly below a programmed threshold. A 16-bit configuration word sets three things: whether qualifying results must arrive back to back or may be spread out, how many qualifying results are needed, and the threshold itself. A polarity input selects how results and threshold are compared. It is either plain binary or two's complement.

Each result is qualified by a valid strobe. A status-read strobe clears the flag and restarts the count. Writing the configuration word also restarts the count and drops the flag. Programming the lowest code of the active number format as the threshold disables the alarm, because no result can fall below it.

Top module: `adc_low_alarm`

## Requirements
- R1: After reset the alarm flag is low and the configuration word is all zero, so threshold 0 with unipolar compare raises no alarm.
- R2: The configuration word holds the threshold in bits 11:0, the count field in bits 14:12 and the mode bit in bit 15. A count field value of K requires K+1 qualifying results, for 1 to 8 in total.
- R3: With the mode bit at 0, every valid result below the threshold advances the count. Valid results at or above the threshold leave the count unchanged.
- R4: With the mode bit at 1, a valid result at or above the threshold returns the count to zero, so the required results must arrive consecutively.
- R5: Once set, the flag stays high until a clear or a configuration write, whatever the later results are.
- R6: A status-read strobe drops the flag and restarts the count from zero.
- R7: Any configuration write drops the flag and restarts the count from zero.
- R8: With the polarity input low, results and threshold are compared as unsigned binary.
- R9: With the polarity input high, results and threshold are compared as two's complement.
- R10: A threshold of 0x000 in unipolar mode, or 0x800 in bipolar mode, never lets the alarm set.
- R11: Results with the valid strobe low have no effect on the count or the flag.
- R12: A clear or configuration write in the same cycle as a qualifying result wins. That result is not counted and the flag is low after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 16 | Configuration word |
| statRdClr | input | 1 | Status read, clears the flag |
| bipolar | input | 1 | 1 = two's complement compare, 0 = unsigned compare |
| sampleValid | input | 1 | Qualifies sampleData |
| sampleData | input | 12 | Conversion result |
| alarmFlag | output | 1 | Sticky under-threshold alarm |

## Verification
The flag is a register. A result, clear or configuration write that is applied before a rising edge shows up on alarmFlag right after that edge, and there is no other latency anywhere in the block. The bench drives each stimulus at the falling edge and compares the flag one time unit after the next rising edge. Every stimulus is therefore judged exactly one cycle later. Count state is never read directly: it is shown through the cycle on which the flag finally rises.

// File: rtl/lta_pkg.sv
package lta_pkg;
  typedef struct packed {
    logic cfgLoad;
    logic cntClear;
    logic cntInc;
  } ltaStrobe_t;
endpackage

// File: rtl/lta_datapath.sv
module lta_datapath
  import lta_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int TRIP_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ltaStrobe_t          strobe,
  input  logic [SAMPLE_W+TRIP_W:0] cfgWrData,
  input  logic                bipolar,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                isBelow,
  output logic                atTarget,
  output logic                modeConsec
);
  localparam int CFG_W = SAMPLE_W + TRIP_W + 1;
  localparam logic [SAMPLE_W-1:0] UNI_MIN = '0;
  localparam logic [SAMPLE_W-1:0] BIP_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [CFG_W-1:0]    cfgReg;
  logic [TRIP_W-1:0]   tripField;
  logic [SAMPLE_W-1:0] threshold;
  logic [TRIP_W-1:0]   tripCnt;
  logic [SAMPLE_W-1:0] sampleKey;
  logic [SAMPLE_W-1:0] threshKey;

  always_ff @(posedge clk) begin
    if (!rstN)                cfgReg <= '0;
    else if (strobe.cfgLoad)  cfgReg <= cfgWrData;
  end

  assign modeConsec = cfgReg[CFG_W-1];
  assign tripField  = cfgReg[CFG_W-2 -: TRIP_W];
  assign threshold  = cfgReg[SAMPLE_W-1:0];

  // Flipping the sign bit maps two's complement order onto unsigned order.
  assign sampleKey = {sampleData[SAMPLE_W-1] ^ bipolar, sampleData[SAMPLE_W-2:0]};
  assign threshKey = {threshold[SAMPLE_W-1] ^ bipolar, threshold[SAMPLE_W-2:0]};
  assign isBelow   = sampleKey < threshKey;

  always_ff @(posedge clk) begin
    if (!rstN)                 tripCnt <= '0;
    else if (strobe.cntClear)  tripCnt <= '0;
    else if (strobe.cntInc)    tripCnt <= tripCnt + 1'b1;
  end

  assign atTarget = (tripCnt == tripField);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    tripCnt <= tripField);

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> (tripCnt == '0));

  assert_min_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((!bipolar && threshold == UNI_MIN) || (bipolar && threshold == BIP_MIN)) |-> !isBelow);
endmodule

// File: rtl/lta_control.sv
module lta_control
  import lta_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       statRdClr,
  input  logic       sampleValid,
  input  logic       isBelow,
  input  logic       atTarget,
  input  logic       modeConsec,
  output ltaStrobe_t strobe,
  output logic       alarmFlag
);
  logic clearReq;
  logic tripHit;

  assign clearReq = cfgWrEn | statRdClr;
  assign tripHit  = !clearReq && !alarmFlag && sampleValid && isBelow && atTarget;

  always_comb begin
    strobe = '0;
    strobe.cfgLoad = cfgWrEn;
    if (clearReq) begin
      strobe.cntClear = 1'b1;
    end else if (!alarmFlag && sampleValid) begin
      if (isBelow && !atTarget)      strobe.cntInc   = 1'b1;
      else if (!isBelow && modeConsec) strobe.cntClear = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         alarmFlag <= 1'b0;
    else if (clearReq) alarmFlag <= 1'b0;
    else if (tripHit)  alarmFlag <= 1'b1;
  end

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !cfgWrEn && !statRdClr) |=> alarmFlag);

  assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn || statRdClr) |=> !alarmFlag);

  assert_rise_needs_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(sampleValid));

  always_comb begin
    if (rstN) assert_strobe_excl_R4: assert (!(strobe.cntClear && strobe.cntInc));
  end
endmodule

// File: rtl/adc_low_alarm.sv
module adc_low_alarm
  import lta_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int TRIP_W   = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWrEn,
  input  logic [SAMPLE_W+TRIP_W:0]     cfgWrData,
  input  logic                         statRdClr,
  input  logic                         bipolar,
  input  logic                         sampleValid,
  input  logic [SAMPLE_W-1:0]          sampleData,
  output logic                         alarmFlag
);
  ltaStrobe_t strobe;
  logic isBelow;
  logic atTarget;
  logic modeConsec;

  lta_datapath #(.SAMPLE_W(SAMPLE_W), .TRIP_W(TRIP_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrData(cfgWrData),
    .bipolar(bipolar), .sampleData(sampleData), .isBelow(isBelow),
    .atTarget(atTarget), .modeConsec(modeConsec)
  );

  lta_control uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .statRdClr(statRdClr),
    .sampleValid(sampleValid), .isBelow(isBelow), .atTarget(atTarget),
    .modeConsec(modeConsec), .strobe(strobe), .alarmFlag(alarmFlag)
  );
endmodule

// File: tb/tb_adc_low_alarm.sv
module tb_adc_low_alarm;
  logic clk = 1'b0;
  logic rstN;
  logic cfgWrEn;
  logic [15:0] cfgWrData;
  logic statRdClr;
  logic bipolar;
  logic sampleValid;
  logic [11:0] sampleData;
  logic alarmFlag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_low_alarm dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .statRdClr(statRdClr), .bipolar(bipolar), .sampleValid(sampleValid),
    .sampleData(sampleData), .alarmFlag(alarmFlag)
  );

  // {op[1:0], data[15:0], bip, valid, expFlag, req[3:0]}; op 0 = sample, 1 = cfg write, 2 = status clear
  localparam int NVEC = 40;
  localparam logic [24:0] VEC [NVEC] = '{
    {2'd1,16'h2064,1'b0,1'b0,1'b0,4'd7},  // R7 cumulative, 3 trips, thr 100
    {2'd0,16'h0032,1'b0,1'b1,1'b0,4'd3},  // R3 50 below, cnt 1
    {2'd0,16'h00C8,1'b0,1'b1,1'b0,4'd3},  // R3 200 above, unchanged
    {2'd0,16'h0064,1'b0,1'b1,1'b0,4'd8},  // R8 equal is not below
    {2'd0,16'h0063,1'b0,1'b1,1'b0,4'd3},  // R3 99, cnt 2
    {2'd0,16'h000A,1'b0,1'b0,1'b0,4'd11}, // R11 invalid ignored
    {2'd0,16'h0000,1'b0,1'b1,1'b1,4'd2},  // R2 third trip sets flag
    {2'd0,16'h01F4,1'b0,1'b1,1'b1,4'd5},  // R5 sticky
    {2'd2,16'h0000,1'b0,1'b0,1'b0,4'd6},  // R6 clear
    {2'd0,16'h0001,1'b0,1'b1,1'b0,4'd6},  // R6 restart cnt 1
    {2'd0,16'h0002,1'b0,1'b1,1'b0,4'd6},
    {2'd0,16'h0003,1'b0,1'b1,1'b1,4'd6},  // R6 three after clear
    {2'd1,16'hA064,1'b0,1'b0,1'b0,4'd7},  // R7 consecutive, 3 trips
    {2'd0,16'h0001,1'b0,1'b1,1'b0,4'd4},
    {2'd0,16'h0002,1'b0,1'b1,1'b0,4'd4},
    {2'd0,16'h0096,1'b0,1'b1,1'b0,4'd4},  // R4 above resets
    {2'd0,16'h0005,1'b0,1'b1,1'b0,4'd4},
    {2'd0,16'h0006,1'b0,1'b1,1'b0,4'd4},
    {2'd0,16'h0007,1'b0,1'b1,1'b1,4'd4},  // R4 three in a row
    {2'd1,16'h0000,1'b0,1'b0,1'b0,4'd10}, // R10 uni min
    {2'd0,16'h0000,1'b0,1'b1,1'b0,4'd10},
    {2'd1,16'h0800,1'b1,1'b0,1'b0,4'd10}, // R10 bip min
    {2'd0,16'h0800,1'b1,1'b1,1'b0,4'd10},
    {2'd0,16'h0000,1'b1,1'b1,1'b0,4'd10},
    {2'd1,16'h0000,1'b1,1'b0,1'b0,4'd9},  // R9 thr 0 signed, 1 trip
    {2'd0,16'h0FFF,1'b1,1'b1,1'b1,4'd9},  // R9 -1 below 0
    {2'd2,16'h0000,1'b1,1'b0,1'b0,4'd9},
    {2'd0,16'h07FF,1'b1,1'b1,1'b0,4'd9},  // R9 2047 not below
    {2'd1,16'h0800,1'b0,1'b0,1'b0,4'd8},  // R8 thr 2048 unsigned
    {2'd0,16'h0FFF,1'b0,1'b1,1'b0,4'd8},  // R8 4095 not below
    {2'd0,16'h07FF,1'b0,1'b1,1'b1,4'd8},  // R8 2047 below
    {2'd1,16'h7005,1'b0,1'b0,1'b0,4'd2},  // R2 8 trips, thr 5
    {2'd0,16'h0000,1'b0,1'b1,1'b0,4'd2},
    {2'd0,16'h0000,1'b0,1'b1,1'b0,4'd2},
    {2'd0,16'h0000,1'b0,1'b1,1'b0,4'd2},
    {2'd0,16'h0000,1'b0,1'b1,1'b0,4'd2},
    {2'd0,16'h0000,1'b0,1'b1,1'b0,4'd2},
    {2'd0,16'h0000,1'b0,1'b1,1'b0,4'd2},
    {2'd0,16'h0000,1'b0,1'b1,1'b0,4'd2},
    {2'd0,16'h0000,1'b0,1'b1,1'b1,4'd2}   // R2 eighth sets flag
  };

  task automatic idleInputs();
    cfgWrEn = 1'b0; cfgWrData = '0; statRdClr = 1'b0;
    sampleValid = 1'b0; sampleData = '0;
  endtask

  task automatic checkFlag(input logic expFlag, input string req);
    compared++;
    if (alarmFlag !== expFlag) begin
      mismatched++;
      $display("FAIL %s: alarmFlag=%0b expected %0b at %0t", req, alarmFlag, expFlag, $time);
    end
  endtask

  // drive at falling edge, judge just after the next rising edge
  task automatic cycleCheck(input logic cw, input logic [15:0] cd, input logic clr,
                            input logic bp, input logic sv, input logic [11:0] sd,
                            input logic expFlag, input string req);
    @(negedge clk);
    cfgWrEn = cw; cfgWrData = cd; statRdClr = clr; bipolar = bp;
    sampleValid = sv; sampleData = sd;
    @(posedge clk); #1;
    checkFlag(expFlag, req);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #100000;
    compared++; mismatched++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish();
  end

  initial begin
    idleInputs(); bipolar = 1'b0; rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1; checkFlag(1'b0, "R1");
    @(negedge clk); rstN = 1'b1;
    // R1 default thr 0 unipolar: sample 0 never trips
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 12'h000, 1'b0, "R1");
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 12'h000, 1'b0, "R1");

    for (int i = 0; i < NVEC; i++) begin
      logic [24:0] v;
      v = VEC[i];
      cycleCheck(v[23], v[22:7], v[24], v[6], v[5], v[18:7], v[4],
                 $sformatf("R%0d vec%0d", v[3:0], i));
    end

    // R12 clear together with a tripping sample (1 trip, thr 5)
    cycleCheck(1'b1, 16'h0005, 1'b0, 1'b0, 1'b0, 12'h0, 1'b0, "R12");
    cycleCheck(1'b0, 16'h0, 1'b1, 1'b0, 1'b1, 12'h001, 1'b0, "R12");
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 12'h001, 1'b0, "R12");
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 12'h001, 1'b1, "R12");
    // R12 config write (2 trips) together with a sample: sample not counted
    cycleCheck(1'b1, 16'h1005, 1'b0, 1'b0, 1'b1, 12'h001, 1'b0, "R12");
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 12'h001, 1'b0, "R12");
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 12'h001, 1'b1, "R12");
    // R5 sticky across invalid and above samples, R11 invalid below after clear
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 12'hFFF, 1'b1, "R5");
    cycleCheck(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 12'h0, 1'b0, "R6");
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, "R11");
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, "R11");
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 12'h000, 1'b0, "R11");
    cycleCheck(1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 12'h000, 1'b1, "R11");

    @(negedge clk); idleInputs();
    repeat (2) @(posedge clk);
    finish();
  end
endmodule